// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block controls the run, idle and power-down states of a small 8-bit controller core. Software writes a 4-bit power-control register. Bit 0 requests idle, bit 1 requests power-down, and bits 2 and 3 are two general-purpose flags. The request takes effect when the core reports that the writing instruction has retired. The block then gates three enables: one for the CPU clock, one for the peripheral clocks (interrupt logic, timers, serial port), and one for the oscillator. While the core is stopped it also holds the bus strobes high and freezes the port outputs.

Idle ends on any enabled pending interrupt. Power-down ends only through one of two enabled active-low external pins, and it does so in two phases:

- A pin going low restarts the oscillator.
- A stabilisation count then runs.
- CPU clocking returns once the count has finished and a pin that went low has been released.

The block reports which source woke it. A reset input must stay low for a set number of clock samples before the block reinitialises the register state. The clock `clk` models the always-available time base. The oscillator, the CPU and the interrupt vectoring are outside the block, and only handshake signals connect to them.

Top module: `lp_seq`

## Requirements
- R1: When bit 0 of the control register is set, bit 1 is clear and `instr_retire` is high while running, then from the next cycle `cpu_ce` is 0 and both `per_ce` and `osc_en` are 1.
- R2: `bus_hold` is 1 whenever the block is in idle, power-down or oscillator wake-up, and 0 while running.
- R3: In idle, `irq_pend` high returns the block to run on the next cycle. Bit 0 is cleared, and `wake_pulse` is high for one cycle with `wake_src` = 2 (the code for a source other than the external pins).
- R4: When bit 1 of the control register is set and `instr_retire` is high while running, the block enters power-down with `cpu_ce`, `per_ce` and `osc_en` all 0. This holds even if bit 0 is also set.
- R5: In power-down, `irq_pend` and low levels on disabled external pins have no effect: `osc_en` stays 0.
- R6: In power-down, an enabled external pin (`ext_n` bit i low with `ext_en` bit i = 1) raises `osc_en` in the same cycle and starts the oscillator wake-up phase on the next edge.
- R7: After wake-up starts, `cpu_ce` stays 0 for at least `STAB_CYC` + 1 cycles. It returns only once one of the pins that went low has been released high. On return, bits 1:0 are cleared and `wake_pulse` fires.
- R8: `wake_src` is 0 for INT0 (`ext_n[0]`) and 1 for INT1 (`ext_n[1]`). If both pins went low during power-down, the one with the higher `ext_pri` bit is reported. If their priorities are equal, INT0 is reported.
- R9: `sfr_init` rises only after `rst_n` has been sampled low on `RST_HOLD` consecutive edges. A shorter low pulse has no effect. While `rst_n` is low in power-down, `osc_en` is 1.
- R10: A reset clears all four control bits to 0 and returns the block to run, whether it was in idle or in power-down. An interrupt wake leaves bits 3:2 unchanged.
- R11: Control-register writes are ignored while `cpu_ce` is 0. The mode logic never changes bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running time base |
| rst_n | input | 1 | Raw active-low reset request |
| pcon_we | input | 1 | Control-register write strobe |
| pcon_wdata | input | 4 | Write data: bit0 idle, bit1 power-down, bits 3:2 flags |
| instr_retire | input | 1 | Current instruction has retired |
| irq_pend | input | 1 | Some enabled interrupt is pending |
| ext_n | input | 2 | External interrupt pins, active low |
| ext_en | input | 2 | Enables for the external pins |
| ext_pri | input | 2 | Priority bit per external pin |
| cpu_ce | output | 1 | CPU clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| bus_hold | output | 1 | Hold strobes high and freeze port outputs |
| pcon_q | output | 4 | Control-register contents |
| sfr_init | output | 1 | Reinitialise special-function registers |
| wake_pulse | output | 1 | One-cycle pulse when the CPU resumes after an interrupt wake |
| wake_src | output | 2 | Wake source: 0 INT0, 1 INT1, 2 other |

## Verification
Two events can fall in the same cycle: the release of one pin and the continued low level of the other while both are held during wake-up. The bench provokes this by pulling both pins low in power-down and then releasing one of them with equal or unequal priorities. The reported source is then judged against the priority rule rather than against the order of release. A second collision is a reset request that arrives during power-down or idle: the raised oscillator enable and the delayed reinitialisation must agree cycle by cycle with the reference model.

// File: rtl/lp_pkg.sv
package lp_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_IDLE = 2'd1,
      ST_PD   = 2'd2,
      ST_WAKE = 2'd3
   } lp_state_e;

   localparam int PC_IDLE = 0;
   localparam int PC_PD   = 1;
   localparam int PC_W    = 4;

   localparam logic [1:0] SRC_INT0  = 2'd0;
   localparam logic [1:0] SRC_INT1  = 2'd1;
   localparam logic [1:0] SRC_OTHER = 2'd2;
endpackage

// File: rtl/lp_rst_filter.sv
module lp_rst_filter #(
   parameter int HOLD = 24
) (
   input  logic clk,
   input  logic rst_n,
   output logic sys_rst
);
   if (HOLD < 2) begin : g_bad_hold
      $error("lp_rst_filter: HOLD must be at least 2");
   end

   logic [HOLD-1:0] hist;

   always_ff @(posedge clk) begin
      hist <= {hist[HOLD-2:0], rst_n};
   end

   assign sys_rst = ~|hist;

   // R9
   rst_release_chk: assert property (@(posedge clk) disable iff (sys_rst)
      rst_n |=> !sys_rst);
endmodule

// File: rtl/lp_wake_arb.sv
module lp_wake_arb #(
   parameter int NPIN = 2
) (
   input  logic            clk,
   input  logic            clr,
   input  logic            arm,
   input  logic [NPIN-1:0] ext_n,
   input  logic [NPIN-1:0] ext_en,
   input  logic [NPIN-1:0] ext_pri,
   output logic            any_low,
   output logic            rel_any,
   output logic [1:0]      pick
);
   if (NPIN != 2) begin : g_bad_npin
      $error("lp_wake_arb: exactly two external pins are supported");
   end

   logic [NPIN-1:0] held;
   logic [NPIN-1:0] rel;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_ff @(posedge clk) begin
         if (clr || !arm) begin
            held[i] <= 1'b0;
            rel[i]  <= 1'b0;
         end else begin
            held[i] <= held[i] | (ext_en[i] & ~ext_n[i]);
            rel[i]  <= rel[i] | (held[i] & ext_n[i]);
         end
      end
   end

   assign any_low = |(ext_en & ~ext_n);
   assign rel_any = |(rel | (held & ext_n));

   always_comb begin
      if (held == 2'b11)
         pick = (ext_pri[1] & ~ext_pri[0]) ? 2'd1 : 2'd0;
      else if (held[1])
         pick = 2'd1;
      else
         pick = 2'd0;
   end

   // R6
   held_sticky_chk: assert property (@(posedge clk) disable iff (clr)
      arm |=> ((held & $past(held)) == $past(held)));
endmodule

// File: rtl/lp_stab_cnt.sv
module lp_stab_cnt #(
   parameter int STAB = 16
) (
   input  logic clk,
   input  logic clr,
   input  logic run,
   output logic done
);
   if (STAB < 1) begin : g_bad_stab
      $error("lp_stab_cnt: STAB must be at least 1");
   end

   localparam int CW = $clog2(STAB + 1);
   localparam logic [CW-1:0] LIMIT = CW'(STAB);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (clr || !run)
         cnt <= '0;
      else if (cnt != LIMIT)
         cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);

   // R7
   stab_hold_chk: assert property (@(posedge clk) disable iff (clr)
      (run && !done) |=> (!run || cnt != '0));
endmodule

// File: rtl/lp_seq.sv
module lp_seq
   import lp_pkg::*;
#(
   parameter int RST_HOLD = 24,
   parameter int STAB_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pcon_we,
   input  logic [3:0] pcon_wdata,
   input  logic       instr_retire,
   input  logic       irq_pend,
   input  logic [1:0] ext_n,
   input  logic [1:0] ext_en,
   input  logic [1:0] ext_pri,
   output logic       cpu_ce,
   output logic       per_ce,
   output logic       osc_en,
   output logic       bus_hold,
   output logic [3:0] pcon_q,
   output logic       sfr_init,
   output logic       wake_pulse,
   output logic [1:0] wake_src
);
   lp_state_e       st;
   logic [PC_W-1:0] pcon_r;
   logic            sys_rst;
   logic            any_low;
   logic            rel_any;
   logic [1:0]      pick;
   logic            stab_done;
   logic            arm;

   lp_rst_filter #(.HOLD(RST_HOLD)) u_rst (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_rst (sys_rst)
   );

   assign arm = (st == ST_PD) || (st == ST_WAKE);

   lp_wake_arb #(.NPIN(2)) u_arb (
      .clk     (clk),
      .clr     (sys_rst),
      .arm     (arm),
      .ext_n   (ext_n),
      .ext_en  (ext_en),
      .ext_pri (ext_pri),
      .any_low (any_low),
      .rel_any (rel_any),
      .pick    (pick)
   );

   lp_stab_cnt #(.STAB(STAB_CYC)) u_stab (
      .clk  (clk),
      .clr  (sys_rst),
      .run  (st == ST_WAKE),
      .done (stab_done)
   );

   always_ff @(posedge clk) begin
      if (sys_rst) begin
         st         <= ST_RUN;
         pcon_r     <= '0;
         wake_pulse <= 1'b0;
         wake_src   <= SRC_INT0;
      end else begin
         wake_pulse <= 1'b0;
         unique case (st)
            ST_RUN: begin
               if (instr_retire && pcon_r[PC_PD])
                  st <= ST_PD;
               else if (instr_retire && pcon_r[PC_IDLE])
                  st <= ST_IDLE;
               if (pcon_we)
                  pcon_r <= pcon_wdata;
            end
            ST_IDLE: begin
               if (irq_pend) begin
                  st          <= ST_RUN;
                  pcon_r[1:0] <= 2'b00;
                  wake_pulse  <= 1'b1;
                  wake_src    <= SRC_OTHER;
               end
            end
            ST_PD: begin
               if (any_low)
                  st <= ST_WAKE;
            end
            ST_WAKE: begin
               if (stab_done && rel_any) begin
                  st          <= ST_RUN;
                  pcon_r[1:0] <= 2'b00;
                  wake_pulse  <= 1'b1;
                  wake_src    <= pick;
               end
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   assign cpu_ce   = (st == ST_RUN);
   assign per_ce   = (st == ST_RUN) || (st == ST_IDLE);
   assign osc_en   = (st != ST_PD) || any_low || !rst_n;
   assign bus_hold = (st != ST_RUN);
   assign pcon_q   = pcon_r;
   assign sfr_init = sys_rst;

   // R1
   idle_entry_chk: assert property (@(posedge clk) disable iff (sys_rst)
      (cpu_ce && pcon_q[0] && !pcon_q[1] && instr_retire) |=> (!cpu_ce && per_ce && osc_en));

   // R4
   pd_entry_chk: assert property (@(posedge clk) disable iff (sys_rst)
      (cpu_ce && pcon_q[1] && instr_retire) |=> (!cpu_ce && !per_ce));

   // R3
   idle_exit_chk: assert property (@(posedge clk) disable iff (sys_rst)
      (per_ce && !cpu_ce && irq_pend) |=> (cpu_ce && wake_pulse && !pcon_q[0]));

   // R11
   flag_keep_chk: assert property (@(posedge clk) disable iff (sys_rst)
      !(pcon_we && cpu_ce) |=> $stable(pcon_q[3:2]));

   // R7
   pulse_run_chk: assert property (@(posedge clk) disable iff (sys_rst)
      wake_pulse |-> (cpu_ce && $past(!cpu_ce)));
endmodule

// File: tb/tb_lp_seq.sv
module tb_lp_seq;
   localparam int HOLD = 24;
   localparam int STAB = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pcon_we = 1'b0;
   logic [3:0] pcon_wdata = 4'h0;
   logic       instr_retire = 1'b0;
   logic       irq_pend = 1'b0;
   logic [1:0] ext_n = 2'b11;
   logic [1:0] ext_en = 2'b00;
   logic [1:0] ext_pri = 2'b00;
   logic       cpu_ce, per_ce, osc_en, bus_hold, sfr_init, wake_pulse;
   logic [3:0] pcon_q;
   logic [1:0] wake_src;

   always #10 clk = ~clk;

   lp_seq #(.RST_HOLD(HOLD), .STAB_CYC(STAB)) dut (
      .clk(clk), .rst_n(rst_n), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
      .instr_retire(instr_retire), .irq_pend(irq_pend), .ext_n(ext_n),
      .ext_en(ext_en), .ext_pri(ext_pri), .cpu_ce(cpu_ce), .per_ce(per_ce),
      .osc_en(osc_en), .bus_hold(bus_hold), .pcon_q(pcon_q), .sfr_init(sfr_init),
      .wake_pulse(wake_pulse), .wake_src(wake_src)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;
   bit finished = 1'b0;

   // reference model state: 0 run, 1 idle, 2 power-down, 3 wake-up
   int       ms = 0;
   bit [3:0] mp = 0;
   bit       mpulse = 0;
   bit [1:0] msrc = 0;
   bit [1:0] mheld = 0, mrel = 0;
   int       mcnt = 0, mlow = 0;

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [1:0] ref_pick(bit [1:0] h, bit [1:0] p);
      if (h == 2'b11) return (p[1] > p[0]) ? 2'd1 : 2'd0;
      return h[1] ? 2'd1 : 2'd0;
   endfunction

   always @(posedge clk) begin
      bit r, arm;
      bit [1:0] low, reln;
      int ns;
      r = (mlow >= HOLD);
      arm = (ms == 2) || (ms == 3);
      low = ext_en & ~ext_n;
      reln = mrel | (mheld & ext_n);
      if (r) begin
         ms = 0; mp = 0; mpulse = 0; msrc = 0; mheld = 0; mrel = 0; mcnt = 0;
      end else begin
         mpulse = 0;
         ns = ms;
         case (ms)
            0: begin
               if (instr_retire && mp[1]) ns = 2;
               else if (instr_retire && mp[0]) ns = 1;
               if (pcon_we) mp = pcon_wdata;
            end
            1: if (irq_pend) begin ns = 0; mp[1:0] = 0; mpulse = 1; msrc = 2; end
            2: if (low != 0) ns = 3;
            default: if (mcnt == STAB && reln != 0) begin
               ns = 0; mp[1:0] = 0; mpulse = 1; msrc = ref_pick(mheld, ext_pri);
            end
         endcase
         if (ms == 3) begin
            if (mcnt != STAB) mcnt++;
         end else mcnt = 0;
         if (arm) begin
            mrel = mrel | (mheld & ext_n);
            mheld = mheld | low;
         end else begin
            mheld = 0; mrel = 0;
         end
         ms = ns;
      end
      if (!rst_n) begin
         if (mlow < HOLD) mlow++;
      end else mlow = 0;
   end

   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (cmp_on && !finished) begin
            chk("R1 cpu_ce", cpu_ce, ms == 0);
            chk("R4 per_ce", per_ce, ms <= 1);
            chk("R6 osc_en", osc_en, (ms != 2) || ((ext_en & ~ext_n) != 0) || !rst_n);
            chk("R2 bus_hold", bus_hold, ms != 0);
            chk("R10 pcon_q", pcon_q, mp);
            chk("R9 sfr_init", sfr_init, mlow >= HOLD);
            chk("R3 wake_pulse", wake_pulse, mpulse);
            chk("R8 wake_src", wake_src, msrc);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_retire(bit [3:0] v);
      pcon_we = 1'b1; pcon_wdata = v;
      tick(1);
      pcon_we = 1'b0; instr_retire = 1'b1;
      tick(1);
      instr_retire = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      tick(30);
      rst_n = 1'b1;
      cmp_on = 1'b1;          // R10 reset state compared from here
      tick(3);
      // R9: a short low pulse is ignored
      rst_n = 1'b0; tick(10); rst_n = 1'b1; tick(2);
      // R1: idle entry with flag gf0 set
      write_retire(4'b0101);
      tick(3);
      // R11: write while the CPU is stopped is ignored
      pcon_we = 1'b1; pcon_wdata = 4'b1110;
      tick(1);
      pcon_we = 1'b0;
      #5 chk("R11 write ignored in idle", pcon_q, 4'b0101);
      tick(3);
      // R3: interrupt ends idle, flags kept
      irq_pend = 1'b1; tick(1); irq_pend = 1'b0;
      tick(4);
      // R4: power-down entry, INT1 enabled only
      ext_en = 2'b10;
      write_retire(4'b0110);
      tick(3);
      // R5: generic interrupt and disabled pin ignored
      irq_pend = 1'b1; ext_n = 2'b10;
      #5 chk("R5 osc stays off", osc_en, 0);
      tick(1);
      irq_pend = 1'b0; ext_n = 2'b11;
      tick(3);
      #5 chk("R5 still in power-down", per_ce, 0);
      tick(1);
      // R6/R7: INT1 low, released before stabilisation ends
      ext_n = 2'b01; tick(3);
      ext_n = 2'b11; tick(2);
      #5 chk("R7 cpu waits for stabilisation", cpu_ce, 0);
      tick(15);
      // R8: both pins, equal priority, INT0 reported
      ext_en = 2'b11; ext_pri = 2'b00;
      write_retire(4'b0010);
      tick(3);
      ext_n = 2'b00; tick(12);
      ext_n = 2'b01; tick(5);
      ext_n = 2'b11; tick(3);
      // R8: INT1 has higher priority
      ext_pri = 2'b10;
      write_retire(4'b0010);
      tick(3);
      ext_n = 2'b00; tick(12);
      ext_n = 2'b10; tick(5);
      ext_n = 2'b11; tick(3);
      // R4 both bits set picks power-down; then R9/R10 reset out of it
      write_retire(4'b1011);
      tick(4);
      rst_n = 1'b0; tick(30); rst_n = 1'b1; tick(5);
      // R10: reset during idle
      write_retire(4'b1001);
      tick(3);
      rst_n = 1'b0; tick(26); rst_n = 1'b1; tick(3);
      #5 chk("R10 cleared after idle reset", pcon_q, 0);
      tick(2);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule